// File: doc/BRIEF.md
# Linear-Chain Ternary Carry-Save Reducer

This block sums many equal-width operands down to two words, a sum word and a carry word. Their modular sum equals the modular sum of every input operand. The reduction is a single linear chain of 5:3 compressor stages. Each stage is a bit-sliced ternary-adder cell in which the two carries travel separately. The short-range carry depends only on the three operand bits of its own cell. The chained carry combines the cell's partial sum with both incoming carries. Both carry words move one bit up and enter the next stage on its two carry inputs.

The first stage takes five words: three on its operand inputs and two on its carry inputs. Each later stage takes three more words. The operands are used first, and then the partial sum words in the order they were made. The last stage is a flush stage that adds the final partial sum to two zero words, so its short-range carry word is zero. The result carry is therefore only the shifted chained-carry word. When the operand count is even, the block appends one zero word so that the count becomes odd. The stage count is (odd count − 1)/2.

The result is registered once behind a synchronous active-high reset. A later carry-propagate adder or another compressor level uses the sum and carry words.

Top module: `tern_chain_reducer`

## Requirements
- R1: One clock after the operands are presented, (res_sum_o + res_carry_o) mod 2^W equals the sum of all NOP operands mod 2^W, for odd NOP ≥ 5.
- R2: res_spill_o, the short-range carry word of the flush stage, is zero after every clock.
- R3: For an even NOP, a zero word is appended and the R1 relation still holds.
- R4: Bit 0 of res_carry_o is always 0, because the chained carry enters the result shifted left by one bit.
- R5: A clock edge with rst high clears res_sum_o, res_carry_o and res_spill_o to zero, whatever the operands are.
- R6: Arithmetic wraps modulo 2^W. With every operand all ones, the result is (−NOP) mod 2^W.
- R7: Operand k is taken from ops_i[k*W +: W], and the smallest configuration (NOP = 5, two stages) obeys R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ops_i | input | NOP*W | Packed operands; operand k is at bits k*W +: W |
| res_sum_o | output | W | Registered sum word |
| res_carry_o | output | W | Registered carry word (chained carry, shifted) |
| res_spill_o | output | W | Registered short-range carry word of the flush stage |

## Verification
The modular total and the zero spill word come out in the same cycle. The spill word is zero only if the flush stage is placed correctly, and the total is right only if every partial sum is re-added exactly once. All-ones operands drive the short-range carry to one in every cell of the early stages. Alternating and random operands then spread those carries through the chain. For each result, the bench checks sum plus carry against its own running total and also checks the spill word and the carry's low bit. Four instances with 5, 6, 7 and 11 operands run on the same stimulus, so the even-count padding and the shortest chain are judged side by side.

// File: rtl/tern_pkg.sv
package tern_pkg;
  // smallest odd count not below n
  function automatic int odd_up(input int n);
    return ((n % 2) == 0) ? n + 1 : n;
  endfunction
endpackage

// File: rtl/cmp53_cell.sv
module cmp53_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  input  logic ca_i,
  input  logic cb_i,
  output logic s_o,
  output logic ca_o,
  output logic cb_o
);
  logic part;
  always_comb begin
    part = x_i ^ y_i ^ z_i;
    ca_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    s_o  = part ^ ca_i ^ cb_i;
    cb_o = (part & ca_i) | (part & cb_i) | (ca_i & cb_i);
  end
endmodule

// File: rtl/cmp53_stage.sv
module cmp53_stage #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic [W-1:0] ca_i,
  input  logic [W-1:0] cb_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] ca_o,
  output logic [W-1:0] cb_o
);
  localparam int EW = W + 3;

  for (genvar b = 0; b < W; b++) begin : g_bit
    cmp53_cell u_cell (
      .x_i (x_i[b]),
      .y_i (y_i[b]),
      .z_i (z_i[b]),
      .ca_i(ca_i[b]),
      .cb_i(cb_i[b]),
      .s_o (s_o[b]),
      .ca_o(ca_o[b]),
      .cb_o(cb_o[b])
    );
  end

  // weighted value in equals weighted value out at full width
  always_comb begin
    if (!$isunknown({x_i, y_i, z_i, ca_i, cb_i, s_o, ca_o, cb_o})) begin
      AST_STAGE_BALANCE: assert ((EW'(x_i) + EW'(y_i) + EW'(z_i) + EW'(ca_i) + EW'(cb_i))
                                 == (EW'(s_o) + (EW'(ca_o) << 1) + (EW'(cb_o) << 1))); // R1
    end
  end
endmodule

// File: rtl/tern_chain_reducer.sv
module tern_chain_reducer #(
  parameter int NOP = 11,
  parameter int W   = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NOP*W-1:0] ops_i,
  output logic [W-1:0]   res_sum_o,
  output logic [W-1:0]   res_carry_o,
  output logic [W-1:0]   res_spill_o
);
  localparam int NODD  = tern_pkg::odd_up(NOP);
  localparam int NST   = (NODD - 1) / 2;
  localparam int NFEED = NODD - 2;

  logic [W-1:0] opw [NODD];
  logic [W-1:0] st_s  [NST];
  logic [W-1:0] st_ca [NST];
  logic [W-1:0] st_cb [NST];

  // operand words, padded with a zero word for an even count
  for (genvar k = 0; k < NODD; k++) begin : g_op
    if (k < NOP) begin : g_real
      assign opw[k] = ops_i[k*W +: W];
    end else begin : g_pad
      assign opw[k] = '0;
    end
  end

  for (genvar j = 0; j < NST; j++) begin : g_st
    logic [W-1:0] in3 [3];
    logic [W-1:0] ai;
    logic [W-1:0] bi;

    if (j == 0) begin : g_head
      assign ai = opw[0];
      assign bi = opw[1];
    end else begin : g_link
      assign ai = st_ca[j-1] << 1;
      assign bi = st_cb[j-1] << 1;
    end

    if (j == NST - 1) begin : g_flush
      assign in3[0] = st_s[j-1];
      assign in3[1] = '0;
      assign in3[2] = '0;
    end else begin : g_feed
      for (genvar k = 0; k < 3; k++) begin : g_pick
        localparam int IDX = 3 * j + k;
        if (IDX < NFEED) begin : g_from_op
          assign in3[k] = opw[IDX + 2];
        end else begin : g_from_sum
          assign in3[k] = st_s[IDX - NFEED];
        end
      end
    end

    cmp53_stage #(.W(W)) u_stage (
      .x_i (in3[0]),
      .y_i (in3[1]),
      .z_i (in3[2]),
      .ca_i(ai),
      .cb_i(bi),
      .s_o (st_s[j]),
      .ca_o(st_ca[j]),
      .cb_o(st_cb[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_sum_o   <= '0;
      res_carry_o <= '0;
      res_spill_o <= '0;
    end else begin
      res_sum_o   <= st_s[NST-1];
      res_carry_o <= st_cb[NST-1] << 1;
      res_spill_o <= st_ca[NST-1];
    end
  end

  // independent modular total of the operands, used only by the checks
  logic [W-1:0] op_total;
  always_comb begin
    op_total = '0;
    for (int k = 0; k < NOP; k++) op_total = op_total + ops_i[k*W +: W];
  end

  AST_TOTAL_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((res_sum_o + res_carry_o) == $past(op_total))); // R1
  AST_SPILL_ZERO: assert property (@(posedge clk) disable iff (rst)
    res_spill_o == '0); // R2
  AST_CARRY_LSB: assert property (@(posedge clk) disable iff (rst)
    res_carry_o[0] == 1'b0); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_sum_o == '0 && res_carry_o == '0 && res_spill_o == '0)); // R5
endmodule

// File: tb/tern_chain_reducer_tb_top.sv
module tern_chain_reducer_tb_top;
  localparam int W = 16;

  typedef struct packed {
    logic [W-1:0] e11;
    logic [W-1:0] e5;
    logic [W-1:0] e7;
    logic [W-1:0] e6;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11*W-1:0] op11 = '0;
  logic [5*W-1:0]  op5  = '0;
  logic [7*W-1:0]  op7  = '0;
  logic [6*W-1:0]  op6  = '0;
  logic [W-1:0] s11, c11, p11, s5, c5, p5, s7, c7, p7, s6, c6, p6;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb [$];

  always #2 clk = ~clk;

  tern_chain_reducer #(.NOP(11), .W(W)) dut_i (
    .clk(clk), .rst(rst), .ops_i(op11), .res_sum_o(s11), .res_carry_o(c11), .res_spill_o(p11));
  tern_chain_reducer #(.NOP(5), .W(W)) dut5_i (
    .clk(clk), .rst(rst), .ops_i(op5), .res_sum_o(s5), .res_carry_o(c5), .res_spill_o(p5));
  tern_chain_reducer #(.NOP(7), .W(W)) dut7_i (
    .clk(clk), .rst(rst), .ops_i(op7), .res_sum_o(s7), .res_carry_o(c7), .res_spill_o(p7));
  tern_chain_reducer #(.NOP(6), .W(W)) dut6_i (
    .clk(clk), .rst(rst), .ops_i(op6), .res_sum_o(s6), .res_carry_o(c6), .res_spill_o(p6));

  task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // driver: mode 0 random, 1 all ones, 2 zeros, 3 alternating, 4 one-hot
  task automatic drive(input int mode);
    exp_t e;
    @(negedge clk);
    e = '0;
    for (int k = 0; k < 11; k++) begin
      logic [W-1:0] v;
      case (mode)
        1: v = '1;
        2: v = '0;
        3: v = (k % 2 == 0) ? 16'hAAAA : 16'h5555;
        4: v = 16'h0001 << (k % W);
        default: v = W'($urandom);
      endcase
      op11[k*W +: W] = v;
      e.e11 = e.e11 + v;
      if (k < 5) begin op5[k*W +: W] = v; e.e5 = e.e5 + v; end
      if (k < 7) begin op7[k*W +: W] = v; e.e7 = e.e7 + v; end
      if (k < 6) begin op6[k*W +: W] = v; e.e6 = e.e6 + v; end
    end
    sb.push_back(e);
  endtask

  // monitor: results appear one edge after the driver's values
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk("R1 total nop11", s11 + c11, e.e11);
      chk("R7 total nop5", s5 + c5, e.e5);
      chk("R1 total nop7", s7 + c7, e.e7);
      chk("R3 total nop6 padded", s6 + c6, e.e6);
      chk("R2 spill zero", p11 | p5 | p7 | p6, '0);
      chk("R4 carry lsb", W'(c11[0] | c5[0] | c7[0] | c6[0]), '0);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op11 = '1; op5 = '1; op7 = '1; op6 = '1;
    repeat (3) @(posedge clk);
    #1;
    // R5: reset clears outputs despite nonzero operands
    chk("R5 reset sum", s11 | s5 | s7 | s6, '0);
    chk("R5 reset carry", c11 | c5 | c7 | c6, '0);
    chk("R5 reset spill", p11 | p5 | p7 | p6, '0);
    @(negedge clk);
    rst = 1'b0;
    drive(1);
    @(posedge clk); #1;
    // R6: all ones wraps to -NOP
    chk("R6 all ones nop11", s11 + c11, W'(-11));
    chk("R6 all ones nop6", s6 + c6, W'(-6));
    drive(2);
    drive(3);
    drive(4);
    drive(1);
    for (int i = 0; i < 60; i++) drive(0);
    repeat (3) @(negedge clk);
    // R5 again: mid-stream reset
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R5 midstream reset", s11 | c11 | s5 | c5, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule